// File: doc/BRIEF.md
# Bus-Matrix Configuration Register Bank

This block is a small memory-mapped bank of configuration registers for an on-chip bus matrix. It sits on a simple 32-bit register bus with an address, a write strobe with write data, and a read strobe with combinational read data. It stores a control word and four partition base addresses: the kernel-program RAM base, the user-data RAM base, the user-program RAM base and the user-program flash base. It drives all five stored values straight out as configuration outputs. Three further slots are read-only and report memory sizes in bytes. The sizes are fixed at build time from kilobyte parameters.

Each writable register can be changed in one bus write through four address aliases, so software never needs a read-modify-write. Bits [3:2] of the offset choose the update:
- plain assignment;
- clearing the bits that are set in the data;
- setting those bits;
- toggling them.

The register window covers 128 bytes. Anything beyond that window is inert.

Top module: `bmx_cfg_bank`

## Requirements
- R1: While `rst_n` is low, the control register is loaded with 0x001F0041 and the four base registers are cleared to 0.
- R2: A write with offset bits [3:2] = 00 replaces the selected register with `bus_wdata` on the clock edge that samples `bus_wr`.
- R3: A write with offset bits [3:2] = 01 clears in the selected register every bit that is 1 in `bus_wdata`.
- R4: A write with offset bits [3:2] = 10 sets in the selected register every bit that is 1 in `bus_wdata`.
- R5: A write with offset bits [3:2] = 11 inverts in the selected register every bit that is 1 in `bus_wdata`.
- R6: While `bus_rd` is high, `bus_rdata` combinationally shows the current value of the addressed slot, whichever of its four aliases is used. While `bus_rd` is low, `bus_rdata` is 0.
- R7: Slot 5 reads `RAM_KB`*1024, slot 6 reads `FLASH_KB`*1024 and slot 7 reads `BOOT_KB`*1024. Writes to these three slots change nothing.
- R8: An access at offset 0x80 or above reads 0, and a write there leaves every register unchanged.
- R9: The five configuration outputs always equal the stored values of their registers.
- R10: Offset bits [6:4] select the slot: 0 is control, 1 is kernel-program RAM base, 2 is user-data RAM base, 3 is user-program RAM base, and 4 is user-program flash base. Offset bits [1:0] play no part in decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | ADDR_W | Byte offset into the bank |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Combinational read data |
| cfg_ctrl | output | DATA_W | Control register value |
| cfg_ram_kprog | output | DATA_W | Kernel-program RAM base |
| cfg_ram_udata | output | DATA_W | User-data RAM base |
| cfg_ram_uprog | output | DATA_W | User-program RAM base |
| cfg_flash_uprog | output | DATA_W | User-program flash base |

## Verification
The bench drives the clear, set and invert aliases against registers that already hold mixed bit patterns, so that a swapped or mis-decoded operation code produces a wrong value instead of a coincidentally correct one. It writes into the size slots and past the 128-byte window, then reads every port back. A decoder that let such writes fall through to slots 0 to 4 would corrupt a base output. It also uses offsets with nonzero bits [1:0] and reads through non-assign aliases, which catches a decoder that shifts its slot or operation field. Finally, it checks that the read data drops to zero while the read strobe is low.

// File: rtl/bmx_cfg_pkg.sv
package bmx_cfg_pkg;

    typedef enum logic [1:0] {
        OP_ASSIGN = 2'b00,
        OP_CLEAR  = 2'b01,
        OP_SET    = 2'b10,
        OP_FLIP   = 2'b11
    } wr_op_e;

    typedef enum logic [2:0] {
        SLOT_CTRL        = 3'd0,
        SLOT_RAM_KPROG   = 3'd1,
        SLOT_RAM_UDATA   = 3'd2,
        SLOT_RAM_UPROG   = 3'd3,
        SLOT_FLASH_UPROG = 3'd4,
        SLOT_RAM_SIZE    = 3'd5,
        SLOT_FLASH_SIZE  = 3'd6,
        SLOT_BOOT_SIZE   = 3'd7
    } slot_e;

    localparam int          WIN_BYTES = 128;
    localparam int          OP_LSB    = 2;
    localparam int          SLOT_LSB  = 4;
    localparam int          SLOT_W    = $clog2(WIN_BYTES) - SLOT_LSB;
    localparam int          NUM_RW    = 5;
    localparam logic [31:0] CTRL_RST  = 32'h001F_0041;

    function automatic logic [31:0] apply_op(wr_op_e op, logic [31:0] cur, logic [31:0] d);
        logic [31:0] r;
        unique case (op)
            OP_ASSIGN: r = d;
            OP_CLEAR:  r = cur & ~d;
            OP_SET:    r = cur | d;
            OP_FLIP:   r = cur ^ d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bmx_addr_decode.sv
module bmx_addr_decode
    import bmx_cfg_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output slot_e             slot,
    output wr_op_e            op
);

    always_comb begin
        in_win = (addr < ADDR_W'(WIN_BYTES));
        slot   = slot_e'(addr[SLOT_LSB +: SLOT_W]);
        op     = wr_op_e'(addr[OP_LSB +: 2]);
    end

endmodule

// File: rtl/bmx_cfg_reg.sv
module bmx_cfg_reg
    import bmx_cfg_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  wr_op_e            op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= apply_op(op, q, wdata);
        end
    end

endmodule

// File: rtl/bmx_rd_mux.sv
module bmx_rd_mux
    import bmx_cfg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RAM_KB   = 128,
    parameter int FLASH_KB = 512,
    parameter int BOOT_KB  = 12
) (
    input  logic              rd,
    input  logic              in_win,
    input  slot_e             slot,
    input  logic [DATA_W-1:0] regs [NUM_RW],
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] RAM_BYTES   = DATA_W'(RAM_KB * 1024);
    localparam logic [DATA_W-1:0] FLASH_BYTES = DATA_W'(FLASH_KB * 1024);
    localparam logic [DATA_W-1:0] BOOT_BYTES  = DATA_W'(BOOT_KB * 1024);

    always_comb begin
        rdata = '0;
        if (rd && in_win) begin
            unique case (slot)
                SLOT_CTRL:        rdata = regs[0];
                SLOT_RAM_KPROG:   rdata = regs[1];
                SLOT_RAM_UDATA:   rdata = regs[2];
                SLOT_RAM_UPROG:   rdata = regs[3];
                SLOT_FLASH_UPROG: rdata = regs[4];
                SLOT_RAM_SIZE:    rdata = RAM_BYTES;
                SLOT_FLASH_SIZE:  rdata = FLASH_BYTES;
                SLOT_BOOT_SIZE:   rdata = BOOT_BYTES;
            endcase
        end
    end

endmodule

// File: rtl/bmx_cfg_bank.sv
module bmx_cfg_bank
    import bmx_cfg_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int RAM_KB   = 128,
    parameter int FLASH_KB = 512,
    parameter int BOOT_KB  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cfg_ctrl,
    output logic [DATA_W-1:0] cfg_ram_kprog,
    output logic [DATA_W-1:0] cfg_ram_udata,
    output logic [DATA_W-1:0] cfg_ram_uprog,
    output logic [DATA_W-1:0] cfg_flash_uprog
);

    logic              in_win;
    slot_e             slot;
    wr_op_e            op;
    logic [DATA_W-1:0] regs [NUM_RW];

    bmx_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr   (bus_addr),
        .in_win (in_win),
        .slot   (slot),
        .op     (op)
    );

    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_G = (g == 0) ? DATA_W'(CTRL_RST) : '0;
        logic we_g;
        assign we_g = bus_wr && in_win && (int'(slot) == g);
        bmx_cfg_reg #(.DATA_W(DATA_W), .RST_VAL(RST_G)) reg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_g),
            .op    (op),
            .wdata (bus_wdata),
            .q     (regs[g])
        );
    end

    bmx_rd_mux #(
        .DATA_W   (DATA_W),
        .RAM_KB   (RAM_KB),
        .FLASH_KB (FLASH_KB),
        .BOOT_KB  (BOOT_KB)
    ) mux_i (
        .rd     (bus_rd),
        .in_win (in_win),
        .slot   (slot),
        .regs   (regs),
        .rdata  (bus_rdata)
    );

    assign cfg_ctrl        = regs[0];
    assign cfg_ram_kprog   = regs[1];
    assign cfg_ram_udata   = regs[2];
    assign cfg_ram_uprog   = regs[3];
    assign cfg_flash_uprog = regs[4];

endmodule

// File: rtl/bmx_cfg_chk.sv
module bmx_cfg_chk #(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int RAM_KB   = 128,
    parameter int FLASH_KB = 512,
    parameter int BOOT_KB  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] cfg_ctrl,
    input logic [DATA_W-1:0] cfg_ram_kprog,
    input logic [DATA_W-1:0] cfg_ram_udata,
    input logic [DATA_W-1:0] cfg_ram_uprog,
    input logic [DATA_W-1:0] cfg_flash_uprog
);

    logic       a_in;
    logic [2:0] a_slot;
    logic [1:0] a_op;

    assign a_in   = bus_addr < ADDR_W'(128);
    assign a_slot = bus_addr[6:4];
    assign a_op   = bus_addr[3:2];

    // R1
    rst_value_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg_ctrl == DATA_W'(32'h001F_0041)) && (cfg_ram_kprog == '0)
                         && (cfg_ram_udata == '0) && (cfg_ram_uprog == '0) && (cfg_flash_uprog == '0));

    // R2
    assign_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a_in && a_slot == 3'd0 && a_op == 2'b00) |=> cfg_ctrl == $past(bus_wdata));

    // R3
    clear_kprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a_in && a_slot == 3'd1 && a_op == 2'b01)
        |=> cfg_ram_kprog == ($past(cfg_ram_kprog) & ~$past(bus_wdata)));

    // R4
    set_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a_in && a_slot == 3'd0 && a_op == 2'b10)
        |=> cfg_ctrl == ($past(cfg_ctrl) | $past(bus_wdata)));

    // R5
    flip_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a_in && a_slot == 3'd4 && a_op == 2'b11)
        |=> cfg_flash_uprog == ($past(cfg_flash_uprog) ^ $past(bus_wdata)));

    // R6
    read_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && a_in && a_slot == 3'd0) |-> bus_rdata == cfg_ctrl);

    // R6
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

    // R7
    ram_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && a_in && a_slot == 3'd5) |-> bus_rdata == DATA_W'(RAM_KB * 1024));

    // R7
    size_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && a_in && a_slot == 3'd6) |-> bus_rdata == DATA_W'(FLASH_KB * 1024));

    // R7
    boot_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && a_in && a_slot == 3'd7) |-> bus_rdata == DATA_W'(BOOT_KB * 1024));

    // R8
    outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !a_in) |=> $stable(cfg_ctrl) && $stable(cfg_ram_kprog) && $stable(cfg_ram_udata)
                              && $stable(cfg_ram_uprog) && $stable(cfg_flash_uprog));

endmodule

bind bmx_cfg_bank bmx_cfg_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RAM_KB   (RAM_KB),
    .FLASH_KB (FLASH_KB),
    .BOOT_KB  (BOOT_KB)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_wdata       (bus_wdata),
    .bus_rd          (bus_rd),
    .bus_rdata       (bus_rdata),
    .cfg_ctrl        (cfg_ctrl),
    .cfg_ram_kprog   (cfg_ram_kprog),
    .cfg_ram_udata   (cfg_ram_udata),
    .cfg_ram_uprog   (cfg_ram_uprog),
    .cfg_flash_uprog (cfg_flash_uprog)
);

// File: tb/bmx_cfg_bank_tb.sv
`timescale 1ns/1ps
module bmx_cfg_bank_tb_top;

    localparam int ADDR_W   = 9;
    localparam int RAM_KB   = 128;
    localparam int FLASH_KB = 512;
    localparam int BOOT_KB  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic [31:0]       cfg_ctrl, cfg_ram_kprog, cfg_ram_udata, cfg_ram_uprog, cfg_flash_uprog;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] model [5];
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    bmx_cfg_bank #(
        .ADDR_W(ADDR_W), .DATA_W(32), .RAM_KB(RAM_KB), .FLASH_KB(FLASH_KB), .BOOT_KB(BOOT_KB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cfg_ctrl(cfg_ctrl), .cfg_ram_kprog(cfg_ram_kprog),
        .cfg_ram_udata(cfg_ram_udata), .cfg_ram_uprog(cfg_ram_uprog), .cfg_flash_uprog(cfg_flash_uprog)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_read(logic [ADDR_W-1:0] a);
        if (a >= ADDR_W'(128)) return 32'h0;
        case (a[6:4])
            3'd5:    return 32'(RAM_KB * 1024);
            3'd6:    return 32'(FLASH_KB * 1024);
            3'd7:    return 32'(BOOT_KB * 1024);
            default: return model[a[6:4]];
        endcase
    endfunction

    task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a < ADDR_W'(128) && a[6:4] < 3'd5) begin
            case (a[3:2])
                2'b00: model[a[6:4]] = d;
                2'b01: model[a[6:4]] = model[a[6:4]] & ~d;
                2'b10: model[a[6:4]] = model[a[6:4]] | d;
                2'b11: model[a[6:4]] = model[a[6:4]] ^ d;
            endcase
        end
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, string tag);
        exp_t e;
        e.val = expect_read(a);
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic check_ports(string tag);
        @(negedge clk);
        check({tag, " ctrl"},   cfg_ctrl,        model[0]);
        check({tag, " kprog"},  cfg_ram_kprog,   model[1]);
        check({tag, " udata"},  cfg_ram_udata,   model[2]);
        check({tag, " uprog"},  cfg_ram_uprog,   model[3]);
        check({tag, " fuprog"}, cfg_flash_uprog, model[4]);
    endtask

    // monitor: pops expected read values when a read is presented
    always @(negedge clk) begin
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                check("R6 unexpected read", bus_rdata, 32'hx);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, bus_rdata, e.val);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model[0] = 32'h001F_0041;
        for (int i = 1; i < 5; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        check_ports("R1");
        do_read(9'h000, "R1 ctrl read");
        do_read(9'h010, "R1 kprog read");

        do_write(9'h020, 32'hDEAD_BEEF);
        do_read(9'h020, "R2 udata assign");
        do_write(9'h000, 32'h0055_AA00);
        do_read(9'h000, "R2 ctrl assign");

        do_write(9'h004, 32'h0005_0A00);
        do_read(9'h00C, "R3 ctrl clear");
        do_write(9'h024, 32'hFF00_00FF);
        do_read(9'h028, "R3 udata clear");

        do_write(9'h018, 32'h0000_F00F);
        do_write(9'h018, 32'h0300_0000);
        do_read(9'h014, "R4 kprog set");

        do_write(9'h03C, 32'hFFFF_0000);
        do_write(9'h03C, 32'h0F0F_0F0F);
        do_read(9'h038, "R5 uprog flip");
        do_write(9'h04C, 32'h8000_0001);
        do_read(9'h044, "R5 flash flip");

        @(posedge clk); #1;
        bus_addr = 9'h000; bus_rd = 1'b0;
        @(negedge clk);
        check("R6 rdata idle", bus_rdata, 32'h0);
        do_read(9'h01C, "R6 alias read");

        do_read(9'h050, "R7 ram size");
        do_read(9'h060, "R7 flash size");
        do_read(9'h070, "R7 boot size");
        do_write(9'h050, 32'h1234_5678);
        do_write(9'h068, 32'hFFFF_FFFF);
        do_write(9'h07C, 32'hFFFF_FFFF);
        do_read(9'h05C, "R7 ram size after write");
        do_read(9'h074, "R7 boot size after write");
        check_ports("R7");

        do_write(9'h080, 32'hFFFF_FFFF);
        do_write(9'h1F8, 32'hFFFF_FFFF);
        do_write(9'h104, 32'hFFFF_FFFF);
        check_ports("R8");
        do_read(9'h080, "R8 read beyond");
        do_read(9'h100, "R8 read far");

        do_write(9'h041, 32'h1D00_4000);
        do_read(9'h043, "R10 low bits ignored");
        do_write(9'h032, 32'h0000_0800);
        do_read(9'h033, "R10 uprog slot");
        check_ports("R9");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) check("R6 scoreboard drained", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule